// File: doc/BRIEF.md
# Main/Side Road Junction Signal Controller

This block sequences the lamps at a junction where a busy main road meets a quieter side road. It walks a fixed ring of phases: main road moving, main road warned, an optional full stop for both roads, side road moving, side road warned, and back to the main road. The length of each phase is measured by an external timer. The timer reports the end of a phase through `phaseExpired`, and this block pulses `phaseStep` so that the timer can reload.

The two green phases are held until there is a reason to leave. The main road keeps its green until a main-road request arrives together with timer expiry. The side road keeps its green until its presence detector is high together with expiry. The full-stop phase is used only when it is requested at the moment the main-road warning phase ends. Without that request, the side road gets its green directly. The lamps depend only on the current phase.

Top module: `traffic_junction_ctrl`

## Requirements
- R1: After a synchronous reset the block shows main green and side red. The lamp vector {mainRed,mainYellow,mainGreen,sideRed,sideYellow,sideGreen} is then 6'b001100.
- R2: In main green the phase advances to main yellow (6'b010100) only on a clock edge where `mainRequest` and `phaseExpired` are both 1. With any other input combination it stays in main green.
- R3: In main yellow, an edge with `phaseExpired`=1 moves to the full-stop phase (6'b100100) if `allRedRequest`=1, and to side green (6'b100001) if it is 0. Without expiry the phase holds.
- R4: In the full-stop phase an edge with `phaseExpired`=1 moves to side green. Otherwise the phase holds, with both roads red.
- R5: In side green the phase advances to side yellow (6'b100010) only when `sidePresent` and `phaseExpired` are both 1. Otherwise it holds.
- R6: In side yellow an edge with `phaseExpired`=1 returns to main green. Otherwise the phase holds.
- R7: In every phase exactly one lamp per road is lit. The road that is not moving shows red.
- R8: `phaseStep` is 1 in exactly those cycles in which the next clock edge will change the phase, including a change forced by reset. It is 0 while the phase holds.
- R9: Asserting `rst` in any phase returns the block to main green at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseExpired | input | 1 | External phase timer has run out |
| mainRequest | input | 1 | Request to end the main-road green |
| allRedRequest | input | 1 | Request for a full-stop phase after main yellow |
| sidePresent | input | 1 | Vehicle present on the side road |
| mainRed | output | 1 | Main road red lamp |
| mainYellow | output | 1 | Main road yellow lamp |
| mainGreen | output | 1 | Main road green lamp |
| sideRed | output | 1 | Side road red lamp |
| sideYellow | output | 1 | Side road yellow lamp |
| sideGreen | output | 1 | Side road green lamp |
| phaseStep | output | 1 | One-cycle pulse before each phase change, used to reload the timer |

## Verification
The phase ring is driven with input patterns that tell apart the inputs each phase needs:
- In main green and side green, expiry alone and the request alone are each applied. Both must leave the phase unchanged. Only the pair together advances.
- Main yellow is exited twice, once with the full-stop request set and once with it clear, to separate the two branches.
- Stray requests are applied during the yellow phases and during the full stop. They must not disturb those phases.
- A reset is applied in side green. This shows that the step pulse anticipates a change forced by reset, and that it stays low while the reset only holds main green.

// File: rtl/tl_pkg.sv
package tl_pkg;

  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_MAIN_GO   = 3'd0,
    PH_MAIN_WARN = 3'd1,
    PH_ALL_STOP  = 3'd2,
    PH_SIDE_GO   = 3'd3,
    PH_SIDE_WARN = 3'd4
  } phase_t;

  // control -> datapath strobe bundle
  typedef struct packed {
    phase_t phase;
    logic   advance;
  } ctrlStrobes_t;

  typedef struct packed {
    logic red;
    logic yellow;
    logic green;
  } lamp_t;

endpackage

// File: rtl/tl_phase_ctrl.sv
module tl_phase_ctrl
  import tl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         phaseExpired,
  input  logic         mainRequest,
  input  logic         allRedRequest,
  input  logic         sidePresent,
  output ctrlStrobes_t strobes
);

  phase_t curPhase;
  phase_t nextPhase;
  phase_t targetPhase;

  always_comb begin
    nextPhase = curPhase;
    case (curPhase)
      PH_MAIN_GO:   if (mainRequest && phaseExpired) nextPhase = PH_MAIN_WARN;
      PH_MAIN_WARN: if (phaseExpired) nextPhase = allRedRequest ? PH_ALL_STOP : PH_SIDE_GO;
      PH_ALL_STOP:  if (phaseExpired) nextPhase = PH_SIDE_GO;
      PH_SIDE_GO:   if (sidePresent && phaseExpired) nextPhase = PH_SIDE_WARN;
      PH_SIDE_WARN: if (phaseExpired) nextPhase = PH_MAIN_GO;
      default:      nextPhase = PH_MAIN_GO;
    endcase
  end

  assign targetPhase = rst ? PH_MAIN_GO : nextPhase;

  always_ff @(posedge clk) begin
    if (rst) curPhase <= PH_MAIN_GO;
    else     curPhase <= nextPhase;
  end

  always_comb begin
    strobes.phase   = curPhase;
    strobes.advance = (targetPhase != curPhase);
  end

  assert_reset_main_R1: assert property (@(posedge clk)
    rst |=> curPhase == PH_MAIN_GO);

  assert_main_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (curPhase == PH_MAIN_GO && !(mainRequest && phaseExpired)) |=> curPhase == PH_MAIN_GO);

  assert_warn_branch_R3: assert property (@(posedge clk) disable iff (rst)
    (curPhase == PH_MAIN_WARN && phaseExpired && allRedRequest) |=> curPhase == PH_ALL_STOP);

  assert_warn_direct_R3: assert property (@(posedge clk) disable iff (rst)
    (curPhase == PH_MAIN_WARN && phaseExpired && !allRedRequest) |=> curPhase == PH_SIDE_GO);

  assert_allstop_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (curPhase == PH_ALL_STOP && phaseExpired) |=> curPhase == PH_SIDE_GO);

  assert_side_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (curPhase == PH_SIDE_GO && !(sidePresent && phaseExpired)) |=> curPhase == PH_SIDE_GO);

  assert_sidewarn_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (curPhase == PH_SIDE_WARN && phaseExpired) |=> curPhase == PH_MAIN_GO);

endmodule

// File: rtl/tl_lamp_drive.sv
module tl_lamp_drive
  import tl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  output lamp_t        mainLamp,
  output lamp_t        sideLamp,
  output logic         phaseStep
);

  always_comb begin
    mainLamp = '0;
    sideLamp = '0;
    case (strobes.phase)
      PH_MAIN_GO:   begin mainLamp.green  = 1'b1; sideLamp.red = 1'b1; end
      PH_MAIN_WARN: begin mainLamp.yellow = 1'b1; sideLamp.red = 1'b1; end
      PH_SIDE_GO:   begin mainLamp.red = 1'b1; sideLamp.green  = 1'b1; end
      PH_SIDE_WARN: begin mainLamp.red = 1'b1; sideLamp.yellow = 1'b1; end
      default:      begin mainLamp.red = 1'b1; sideLamp.red    = 1'b1; end
    endcase
  end

  assign phaseStep = strobes.advance;

  assert_one_lamp_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(mainLamp) == 1 && $countones(sideLamp) == 1);

  assert_one_red_min_R7: assert property (@(posedge clk) disable iff (rst)
    mainLamp.red || sideLamp.red);

  assert_step_changes_R8: assert property (@(posedge clk) disable iff (rst)
    phaseStep |=> !$stable(strobes.phase));

  assert_nostep_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !phaseStep |=> $stable(strobes.phase));

endmodule

// File: rtl/traffic_junction_ctrl.sv
module traffic_junction_ctrl
  import tl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic phaseExpired,
  input  logic mainRequest,
  input  logic allRedRequest,
  input  logic sidePresent,
  output logic mainRed,
  output logic mainYellow,
  output logic mainGreen,
  output logic sideRed,
  output logic sideYellow,
  output logic sideGreen,
  output logic phaseStep
);

  ctrlStrobes_t strobes;
  lamp_t        mainLamp;
  lamp_t        sideLamp;

  tl_phase_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .phaseExpired  (phaseExpired),
    .mainRequest   (mainRequest),
    .allRedRequest (allRedRequest),
    .sidePresent   (sidePresent),
    .strobes       (strobes)
  );

  tl_lamp_drive u_lamps (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .mainLamp  (mainLamp),
    .sideLamp  (sideLamp),
    .phaseStep (phaseStep)
  );

  assign mainRed    = mainLamp.red;
  assign mainYellow = mainLamp.yellow;
  assign mainGreen  = mainLamp.green;
  assign sideRed    = sideLamp.red;
  assign sideYellow = sideLamp.yellow;
  assign sideGreen  = sideLamp.green;

endmodule

// File: tb/tb_traffic_junction_ctrl.sv
module tb_traffic_junction_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phaseExpired = 1'b0, mainRequest = 1'b0, allRedRequest = 1'b0, sidePresent = 1'b0;
  logic mainRed, mainYellow, mainGreen, sideRed, sideYellow, sideGreen, phaseStep;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  traffic_junction_ctrl dut (
    .clk(clk), .rst(rst), .phaseExpired(phaseExpired), .mainRequest(mainRequest),
    .allRedRequest(allRedRequest), .sidePresent(sidePresent),
    .mainRed(mainRed), .mainYellow(mainYellow), .mainGreen(mainGreen),
    .sideRed(sideRed), .sideYellow(sideYellow), .sideGreen(sideGreen),
    .phaseStep(phaseStep)
  );

  localparam logic [5:0] L_MG = 6'b001100;
  localparam logic [5:0] L_MW = 6'b010100;
  localparam logic [5:0] L_AS = 6'b100100;
  localparam logic [5:0] L_SG = 6'b100001;
  localparam logic [5:0] L_SW = 6'b100010;

  // {mainRequest, allRedRequest, sidePresent, phaseExpired, lamps[5:0], phaseStep}
  localparam int NV = 17;
  localparam logic [10:0] VEC [NV] = '{
    {4'b0001, L_MG, 1'b0},  // R2 expiry alone holds
    {4'b1000, L_MG, 1'b0},  // R2 request alone holds
    {4'b1001, L_MG, 1'b1},  // R2 both advance
    {4'b0100, L_MW, 1'b0},  // R3 no expiry holds
    {4'b0101, L_MW, 1'b1},  // R3 to full stop
    {4'b1010, L_AS, 1'b0},  // R4 holds
    {4'b0001, L_AS, 1'b1},  // R4 exit
    {4'b0001, L_SG, 1'b0},  // R5 expiry alone holds
    {4'b0010, L_SG, 1'b0},  // R5 presence alone holds
    {4'b0011, L_SG, 1'b1},  // R5 both advance
    {4'b1110, L_SW, 1'b0},  // R6 holds
    {4'b0001, L_SW, 1'b1},  // R6 exit
    {4'b1101, L_MG, 1'b1},  // R2 advance
    {4'b0001, L_MW, 1'b1},  // R3 direct to side green
    {4'b1011, L_SG, 1'b1},  // R5
    {4'b0001, L_SW, 1'b1},  // R6
    {4'b0000, L_MG, 1'b0}   // R2 idle
  };

  function automatic logic [5:0] lamps();
    return {mainRed, mainYellow, mainGreen, sideRed, sideYellow, sideGreen};
  endfunction

  task automatic chkLamps(input logic [5:0] exp, input string tag);
    total++;
    if (lamps() !== exp) begin
      bad++;
      $display("FAIL %s lamps actual=%b expected=%b", tag, lamps(), exp);
    end
  endtask

  task automatic chkStep(input logic exp, input string tag);
    total++;
    if (phaseStep !== exp) begin
      bad++;
      $display("FAIL %s phaseStep actual=%b expected=%b", tag, phaseStep, exp);
    end
  endtask

  task automatic chkOneLamp(input string tag);
    total++;
    if ($countones({mainRed, mainYellow, mainGreen}) != 1 ||
        $countones({sideRed, sideYellow, sideGreen}) != 1 || !(mainRed || sideRed)) begin
      bad++;
      $display("FAIL %s lamp count actual=%b expected=one per road with a red", tag, lamps());
    end
  endtask

  task automatic drive(input logic [3:0] v);
    {mainRequest, allRedRequest, sidePresent, phaseExpired} = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chkLamps(L_MG, "R1 reset state");
    chkStep(1'b0, "R1 reset state step");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][10:7]);
      #1;
      chkLamps(VEC[i][6:1], $sformatf("table step %0d (R2 R3 R4 R5 R6)", i));
      chkStep(VEC[i][0], $sformatf("table step %0d (R8)", i));
      chkOneLamp($sformatf("table step %0d (R7)", i));
    end

    // R2: long hold with request but no expiry
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      drive(4'b1100);
      #1;
      chkLamps(L_MG, "R2 long hold");
    end

    // move to side green, then reset there
    @(negedge clk); drive(4'b1001);
    @(negedge clk); drive(4'b0001);
    @(negedge clk); drive(4'b0000);
    #1;
    chkLamps(L_SG, "R9 precondition side green");
    chkStep(1'b0, "R8 hold in side green");
    rst = 1'b1;
    #1;
    chkStep(1'b1, "R8 reset-forced change");
    @(negedge clk);
    #1;
    chkLamps(L_MG, "R9 reset from side green");
    chkStep(1'b0, "R8 reset while in main green");
    rst = 1'b0;
    @(negedge clk);
    #1;
    chkLamps(L_MG, "R1 after release");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule